// File: doc/BRIEF.md
# Critical-Word-First Line Refill Engine

This block services a cacheable load that missed in the data cache. It fetches the whole cache line over a pipelined Wishbone read. The bus is as wide as one row of the data array, 64 bits. The dword the load asked for goes out on the bus first. The other dwords of the line follow in wrap-around order, with only the dword index stepping and the line base held fixed. Each returning beat is written into the selected victim way of the data array, at the row index formed from the set and the dword index. The missing load is answered straight from the bus beat through a forwarding register, so it never waits for the array.

Each dword of the line under refill has its own arrival flag. A later load to the same line finishes as soon as its dword is present. If its dword has not yet come back, the load is parked and then completes on the cycle after that dword arrives. For the whole of the refill the engine reports busy. It stalls any second miss, and it stalls any load to the refill line that arrives while the single wait slot is taken. The tag and line-valid write for the victim way comes only after the last beat has been acknowledged.

Top module: `cwf_refill`

## Requirements
- R1: In reset, and on the first cycle after reset, `busy_o`, `wb_cyc_o`, `wb_stb_o`, `ld_done_o`, `arr_we_o` and `tag_we_o` are all low. An asynchronous reset during a refill abandons the refill.
- R2: A load with `ld_valid_i` and `ld_miss_i` high while idle starts a refill. On the next cycle `busy_o`, `wb_cyc_o` and `wb_stb_o` are high, and `wb_adr_o` is the load address with its low 3 bits cleared, which is the requested dword.
- R3: The k-th accepted strobe (k = 0..7) has address bits [5:3] equal to (requested index + k) mod 8, and bits [31:6] equal to the line base. Exactly 8 strobes are issued. While `wb_stall_i` is high the strobe and its address are held.
- R4: In every cycle with `wb_ack_i` during the refill, `arr_we_o` is high. `arr_data_o` equals `wb_dat_i` and `arr_way_o` is the way captured at the miss. `arr_row_o` is {set = address[11:6], dword index}, where the n-th acknowledge carries index (requested index + n) mod 8.
- R5: `ld_done_o` pulses for one cycle, the cycle after the requested dword is acknowledged. In that cycle `ld_data_o` equals the bus data of that beat.
- R6: While busy, a load with the same address bits [31:6] as the refill line, arriving with the wait slot free, completes on the next cycle with that dword's data if the dword has already arrived or arrives in the same cycle.
- R7: Such a load whose dword has not arrived is held. It completes on the cycle after that dword's acknowledge, carrying that beat's data.
- R8: While idle, `ld_stall_o` is low. While busy, a valid load is stalled if it targets the refill line while the wait slot is taken, or if it targets another line with `ld_miss_i` high. A stalled load produces no completion and does not change the refill.
- R9: `tag_we_o` pulses for one cycle, the cycle after the last acknowledge. It carries the refill tag (address bits [31:12]), the set and the victim way. `busy_o` falls on the cycle after that.
- R10: The per-dword arrival flags are cleared when a refill starts. A later load must wait for its dword in the current refill even if that index arrived in an earlier refill.
- R11: A valid load with `ld_miss_i` low while idle starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_valid_i | input | 1 | Load request from the tag-match stage |
| ld_miss_i | input | 1 | Tag match reported a cacheable miss |
| ld_addr_i | input | 32 | Load byte address |
| ld_way_i | input | 2 | Victim way chosen during tag match |
| ld_stall_o | output | 1 | Load cannot be taken this cycle |
| ld_done_o | output | 1 | Load completion pulse |
| ld_data_o | output | 64 | Load result dword |
| busy_o | output | 1 | Refill in progress |
| wb_cyc_o | output | 1 | Bus cycle active |
| wb_stb_o | output | 1 | Bus read strobe |
| wb_adr_o | output | 32 | Bus byte address, dword aligned |
| wb_stall_i | input | 1 | Bus cannot accept the strobe |
| wb_ack_i | input | 1 | Read beat returned |
| wb_dat_i | input | 64 | Read beat data |
| arr_we_o | output | 1 | Data array write enable |
| arr_way_o | output | 2 | Data array way |
| arr_row_o | output | 9 | Data array row {set, dword} |
| arr_data_o | output | 64 | Data array write data |
| tag_we_o | output | 1 | Tag and line-valid write enable |
| tag_way_o | output | 2 | Tag write way |
| tag_set_o | output | 6 | Tag write set |
| tag_o | output | 20 | Tag value |

## Verification
The checker assumes a well-behaved pipelined slave. It acknowledges only strobes it has already accepted, in order, at most one per cycle and never in the cycle the strobe is accepted. It raises `wb_stall_i` only as a hold on a pending strobe. The bench slave counts accepted strobes against acknowledges and gates its acknowledge patterns on that count, so it never acknowledges ahead. Load requests are driven for a single cycle and dropped rather than retried when stalled. This matches the assumption that the engine owes nothing to a stalled request.

// File: rtl/refill_pkg.sv
package refill_pkg;
  typedef enum logic [1:0] {
    RF_IDLE  = 2'd0,
    RF_FETCH = 2'd1,
    RF_TAGWR = 2'd2
  } rf_state_e;
endpackage

// File: rtl/rf_bus_seq.sv
module rf_bus_seq #(
  parameter int LINE_DW = 8,
  localparam int IDX_W = $clog2(LINE_DW),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] crit_i,
  input  logic             active_i,
  input  logic             stall_i,
  input  logic             ack_i,
  output logic             stb_o,
  output logic [IDX_W-1:0] req_idx_o,
  output logic [IDX_W-1:0] ack_idx_o,
  output logic             last_ack_o
);
  logic [CNT_W-1:0] req_cnt_q, ack_cnt_q;
  logic [IDX_W-1:0] crit_q;

  assign stb_o      = active_i && (req_cnt_q != CNT_W'(LINE_DW));
  // wrap within the line: index width truncates the sum
  assign req_idx_o  = crit_q + req_cnt_q[IDX_W-1:0];
  assign ack_idx_o  = crit_q + ack_cnt_q[IDX_W-1:0];
  assign last_ack_o = active_i && ack_i && (ack_cnt_q == CNT_W'(LINE_DW - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_cnt_q <= '0;
      ack_cnt_q <= '0;
      crit_q    <= '0;
    end else if (start_i) begin
      req_cnt_q <= '0;
      ack_cnt_q <= '0;
      crit_q    <= crit_i;
    end else if (active_i) begin
      if (stb_o && !stall_i) req_cnt_q <= req_cnt_q + 1'b1;
      if (ack_i)             ack_cnt_q <= ack_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rf_line_buf.sv
module rf_line_buf #(
  parameter int DATA_W  = 64,
  parameter int LINE_DW = 8,
  localparam int IDX_W = $clog2(LINE_DW)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               wr_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic [LINE_DW-1:0] vld_o
);
  logic [DATA_W-1:0] word_q [LINE_DW];

  for (genvar g = 0; g < LINE_DW; g++) begin : g_dw
    logic hit;
    assign hit = wr_i && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      vld_o[g] <= 1'b0;
      else if (clear_i) vld_o[g] <= 1'b0;
      else if (hit)     vld_o[g] <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (hit) word_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = word_q[rd_idx_i];
endmodule

// File: rtl/rf_waiter.sv
module rf_waiter #(
  parameter int DATA_W  = 64,
  parameter int LINE_DW = 8,
  localparam int IDX_W = $clog2(LINE_DW)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [IDX_W-1:0]   crit_i,
  input  logic               new_ld_i,
  input  logic [IDX_W-1:0]   new_idx_i,
  input  logic [LINE_DW-1:0] vld_i,
  input  logic               ack_i,
  input  logic [IDX_W-1:0]   ack_idx_i,
  input  logic [DATA_W-1:0]  ack_data_i,
  input  logic [DATA_W-1:0]  buf_data_i,
  output logic               wait_v_o,
  output logic               done_o,
  output logic [DATA_W-1:0]  data_o
);
  logic [IDX_W-1:0] wait_idx_q;
  logic             wait_hit, new_fwd, new_have;

  assign wait_hit = wait_v_o && ack_i && (ack_idx_i == wait_idx_q);
  assign new_fwd  = ack_i && (ack_idx_i == new_idx_i);
  assign new_have = new_fwd || vld_i[new_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_v_o   <= 1'b0;
      wait_idx_q <= '0;
      done_o     <= 1'b0;
      data_o     <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        wait_v_o   <= 1'b1;
        wait_idx_q <= crit_i;
      end else if (wait_hit) begin
        wait_v_o <= 1'b0;
        done_o   <= 1'b1;
        data_o   <= ack_data_i;
      end else if (new_ld_i) begin
        if (new_have) begin
          done_o <= 1'b1;
          data_o <= new_fwd ? ack_data_i : buf_data_i;
        end else begin
          wait_v_o   <= 1'b1;
          wait_idx_q <= new_idx_i;
        end
      end
    end
  end
endmodule

// File: rtl/cwf_refill.sv
module cwf_refill
  import refill_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 64,
  parameter int LINE_DW = 8,
  parameter int SETS    = 64,
  parameter int WAYS    = 4,
  localparam int OFF_W  = $clog2(DATA_W / 8),
  localparam int IDX_W  = $clog2(LINE_DW),
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int LINE_W = ADDR_W - OFF_W - IDX_W,
  localparam int TAG_W  = LINE_W - SET_W,
  localparam int ROW_W  = SET_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_valid_i,
  input  logic              ld_miss_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [WAY_W-1:0]  ld_way_i,
  output logic              ld_stall_o,
  output logic              ld_done_o,
  output logic [DATA_W-1:0] ld_data_o,
  output logic              busy_o,
  output logic              wb_cyc_o,
  output logic              wb_stb_o,
  output logic [ADDR_W-1:0] wb_adr_o,
  input  logic              wb_stall_i,
  input  logic              wb_ack_i,
  input  logic [DATA_W-1:0] wb_dat_i,
  output logic              arr_we_o,
  output logic [WAY_W-1:0]  arr_way_o,
  output logic [ROW_W-1:0]  arr_row_o,
  output logic [DATA_W-1:0] arr_data_o,
  output logic              tag_we_o,
  output logic [WAY_W-1:0]  tag_way_o,
  output logic [SET_W-1:0]  tag_set_o,
  output logic [TAG_W-1:0]  tag_o
);
  rf_state_e         state_q, state_d;
  logic [LINE_W-1:0] line_q;
  logic [WAY_W-1:0]  way_q;
  logic [LINE_W-1:0] ld_line;
  logic [IDX_W-1:0]  ld_idx;
  logic              unused_off;
  logic              fetching, start, same_line, new_ld, wait_v, ack_in;
  logic              last_ack;
  logic [IDX_W-1:0]  req_idx, ack_idx;
  logic [DATA_W-1:0] buf_rd;
  logic [LINE_DW-1:0] vld;

  assign ld_line    = ld_addr_i[ADDR_W-1 -: LINE_W];
  assign ld_idx     = ld_addr_i[OFF_W +: IDX_W];
  assign unused_off = ^ld_addr_i[OFF_W-1:0];

  assign fetching  = (state_q == RF_FETCH);
  assign busy_o    = (state_q != RF_IDLE);
  assign start     = (state_q == RF_IDLE) && ld_valid_i && ld_miss_i;
  assign same_line = (ld_line == line_q);
  assign ld_stall_o = busy_o && ld_valid_i && (same_line ? wait_v : ld_miss_i);
  assign new_ld    = busy_o && ld_valid_i && same_line && !wait_v;
  assign ack_in    = fetching && wb_ack_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RF_IDLE:  if (start) state_d = RF_FETCH;
      RF_FETCH: if (last_ack) state_d = RF_TAGWR;
      RF_TAGWR: state_d = RF_IDLE;
      default:  state_d = RF_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RF_IDLE;
      line_q  <= '0;
      way_q   <= '0;
    end else begin
      state_q <= state_d;
      if (start) begin
        line_q <= ld_line;
        way_q  <= ld_way_i;
      end
    end
  end

  rf_bus_seq #(.LINE_DW(LINE_DW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .crit_i     (ld_idx),
    .active_i   (fetching),
    .stall_i    (wb_stall_i),
    .ack_i      (wb_ack_i),
    .stb_o      (wb_stb_o),
    .req_idx_o  (req_idx),
    .ack_idx_o  (ack_idx),
    .last_ack_o (last_ack)
  );

  rf_line_buf #(.DATA_W(DATA_W), .LINE_DW(LINE_DW)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (start),
    .wr_i      (ack_in),
    .wr_idx_i  (ack_idx),
    .wr_data_i (wb_dat_i),
    .rd_idx_i  (ld_idx),
    .rd_data_o (buf_rd),
    .vld_o     (vld)
  );

  rf_waiter #(.DATA_W(DATA_W), .LINE_DW(LINE_DW)) u_wait (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .crit_i     (ld_idx),
    .new_ld_i   (new_ld),
    .new_idx_i  (ld_idx),
    .vld_i      (vld),
    .ack_i      (ack_in),
    .ack_idx_i  (ack_idx),
    .ack_data_i (wb_dat_i),
    .buf_data_i (buf_rd),
    .wait_v_o   (wait_v),
    .done_o     (ld_done_o),
    .data_o     (ld_data_o)
  );

  assign wb_cyc_o   = fetching;
  assign wb_adr_o   = {line_q, req_idx, {OFF_W{1'b0}}};
  assign arr_we_o   = ack_in;
  assign arr_way_o  = way_q;
  assign arr_row_o  = {line_q[SET_W-1:0], ack_idx};
  assign arr_data_o = wb_dat_i;
  assign tag_we_o   = (state_q == RF_TAGWR);
  assign tag_way_o  = way_q;
  assign tag_set_o  = line_q[SET_W-1:0];
  assign tag_o      = line_q[LINE_W-1:SET_W];
endmodule

// File: rtl/cwf_refill_chk.sv
module cwf_refill_chk #(
  parameter int ADDR_W = 32,
  parameter int LINE_B = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              ld_stall_o,
  input logic              ld_done_o,
  input logic              wb_cyc_o,
  input logic              wb_stb_o,
  input logic [ADDR_W-1:0] wb_adr_o,
  input logic              wb_stall_i,
  input logic              wb_ack_i,
  input logic              arr_we_o,
  input logic              tag_we_o
);
  a_r2_stb_in_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_stb_o |-> wb_cyc_o && busy_o);

  a_r3_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_stb_o && wb_stall_i |=> wb_stb_o && $stable(wb_adr_o));

  a_r3_line_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_stb_o && $past(wb_stb_o) |->
      wb_adr_o[ADDR_W-1:LINE_B] == $past(wb_adr_o[ADDR_W-1:LINE_B]));

  a_r4_write_in_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> wb_cyc_o && wb_ack_i);

  a_r5_done_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_done_o |-> $past(busy_o));

  a_r8_idle_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !ld_stall_o);

  a_r9_tag_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_we_o |-> $past(wb_ack_i) && !wb_cyc_o);

  a_r9_tag_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_we_o |=> !tag_we_o && !busy_o);
endmodule

bind cwf_refill cwf_refill_chk #(.ADDR_W(ADDR_W), .LINE_B(OFF_W + IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .ld_stall_o (ld_stall_o),
  .ld_done_o  (ld_done_o),
  .wb_cyc_o   (wb_cyc_o),
  .wb_stb_o   (wb_stb_o),
  .wb_adr_o   (wb_adr_o),
  .wb_stall_i (wb_stall_i),
  .wb_ack_i   (wb_ack_i),
  .arr_we_o   (arr_we_o),
  .tag_we_o   (tag_we_o)
);

// File: tb/sim_cwf_refill.sv
`timescale 1ns/1ps
module sim_cwf_refill;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ld_valid_i = 1'b0, ld_miss_i = 1'b0;
  logic [31:0] ld_addr_i = '0;
  logic [1:0]  ld_way_i = '0;
  logic        ld_stall_o, ld_done_o, busy_o;
  logic [63:0] ld_data_o;
  logic        wb_cyc_o, wb_stb_o;
  logic [31:0] wb_adr_o;
  logic        wb_stall_i = 1'b0, wb_ack_i = 1'b0;
  logic [63:0] wb_dat_i = '0;
  logic        arr_we_o, tag_we_o;
  logic [1:0]  arr_way_o, tag_way_o;
  logic [8:0]  arr_row_o;
  logic [63:0] arr_data_o;
  logic [5:0]  tag_set_o;
  logic [19:0] tag_o;

  always #10 clk_i = ~clk_i;

  cwf_refill u0 (.*);

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] bus_word(input logic [31:0] a);
    return {~a, a ^ 32'h5A5A_0000};
  endfunction

  // {addr, way, stall mode, ack mode, probe cycle (FF none), probe dword, probe other-line miss}
  localparam int NV = 6;
  localparam logic [49:0] VEC [NV] = '{
    {32'h0000_1028, 2'd2, 2'd0, 2'd0, 8'd3,   3'd3, 1'b0},  // R7 late dword
    {32'h0000_2F40, 2'd1, 2'd1, 2'd0, 8'd5,   3'd1, 1'b0},  // R6 dword present
    {32'h8765_43F8, 2'd3, 2'd0, 2'd1, 8'd1,   3'd2, 1'b0},  // R8 slot taken
    {32'h1234_5650, 2'd0, 2'd2, 2'd2, 8'd2,   3'd0, 1'b1},  // R8 other-line miss
    {32'h0000_1000, 2'd0, 2'd0, 2'd1, 8'd2,   3'd5, 1'b0},  // R10 flags cleared
    {32'hFFFF_FFF0, 2'd1, 2'd1, 2'd2, 8'hFF,  3'd0, 1'b0}
  };

  task automatic run_vec(input logic [49:0] v);
    logic [31:0] a, base, ack_a;
    logic [1:0]  way, sm, am;
    logic [7:0]  pcyc;
    logic [2:0]  pdw, crit, ack_idx;
    logic        pk, stall, ack, probe, stb_exp, w_v, exp_done, nd;
    logic [2:0]  w_i;
    logic [63:0] exp_data, nddata;
    logic [31:0] q [8];
    logic [7:0]  arrived;
    int issued, acked, cyc;
    a = v[49:18]; way = v[17:16]; sm = v[15:14]; am = v[13:12];
    pcyc = v[11:4]; pdw = v[3:1]; pk = v[0];
    base = {a[31:6], 6'b0}; crit = a[5:3];
    @(negedge clk_i);
    ld_valid_i = 1'b1; ld_miss_i = 1'b1; ld_addr_i = a; ld_way_i = way;
    #1 chk(!ld_stall_o, "R8", "idle miss stall", 64'(ld_stall_o), 0);
    @(negedge clk_i);
    issued = 0; acked = 0; cyc = 0; arrived = '0;
    w_v = 1'b1; w_i = crit; exp_done = 1'b0; exp_data = '0;
    while (acked < 8) begin
      stall = (sm == 2'd1) ? cyc[0] : (sm == 2'd2) ? (cyc % 3 == 0) : 1'b0;
      ack = (acked < issued) &&
            ((am == 2'd1) ? cyc[0] : (am == 2'd2) ? (cyc % 3 == 2) : 1'b1);
      ack_a = (acked < 8) ? q[acked[2:0]] : '0;
      ack_idx = ack_a[5:3];
      wb_stall_i = stall; wb_ack_i = ack; wb_dat_i = ack ? bus_word(ack_a) : '0;
      probe = (cyc == int'(pcyc));
      ld_valid_i = probe; ld_miss_i = probe && pk;
      ld_addr_i = pk ? (a ^ 32'h0001_0000) : (base | {26'd0, pdw, 3'd0});
      #1;
      stb_exp = (issued < 8);
      chk(busy_o && wb_cyc_o, "R2", "busy/cyc", {62'd0, busy_o, wb_cyc_o}, 64'd3);
      chk(wb_stb_o == stb_exp, "R3", "strobe count", 64'(wb_stb_o), 64'(stb_exp));
      if (stb_exp)
        chk(wb_adr_o == (base | {26'd0, 3'(crit + 3'(issued)), 3'd0}),
            (issued == 0) ? "R2" : "R3", "address", 64'(wb_adr_o),
            64'(base | {26'd0, 3'(crit + 3'(issued)), 3'd0}));
      chk(ld_done_o == exp_done, "R5/R6/R7/R10", "done", 64'(ld_done_o), 64'(exp_done));
      if (exp_done) chk(ld_data_o == exp_data, "R5/R6/R7", "data", ld_data_o, exp_data);
      chk(arr_we_o == ack, "R4", "array we", 64'(arr_we_o), 64'(ack));
      if (ack) begin
        chk(arr_row_o == {a[11:6], 3'(crit + 3'(acked))}, "R4", "row",
            64'(arr_row_o), 64'({a[11:6], 3'(crit + 3'(acked))}));
        chk(arr_way_o == way && arr_data_o == bus_word(ack_a), "R4", "way/data",
            arr_data_o, bus_word(ack_a));
      end
      if (probe)
        chk(ld_stall_o == (pk | w_v), "R8", "probe stall", 64'(ld_stall_o), 64'(pk | w_v));
      nd = 1'b0; nddata = '0;
      if (w_v && ack && ack_idx == w_i) begin
        nd = 1'b1; nddata = bus_word(ack_a); w_v = 1'b0;
      end else if (probe && !pk && !w_v) begin
        if (arrived[pdw] || (ack && ack_idx == pdw)) begin
          nd = 1'b1; nddata = bus_word(base | {26'd0, pdw, 3'd0});
        end else begin
          w_v = 1'b1; w_i = pdw;
        end
      end
      if (ack) begin arrived[ack_idx] = 1'b1; acked++; end
      if (stb_exp && !stall) begin
        q[issued[2:0]] = base | {26'd0, 3'(crit + 3'(issued)), 3'd0};
        issued++;
      end
      exp_done = nd; exp_data = nddata; cyc++;
      @(negedge clk_i);
    end
    ld_valid_i = 1'b0; ld_miss_i = 1'b0; wb_ack_i = 1'b0; wb_stall_i = 1'b0;
    #1;
    chk(tag_we_o && busy_o && !wb_cyc_o, "R9", "tag write cycle",
        {61'd0, tag_we_o, busy_o, wb_cyc_o}, 64'd6);
    chk(tag_o == a[31:12] && tag_set_o == a[11:6] && tag_way_o == way, "R9", "tag fields",
        {tag_o, tag_set_o, tag_way_o}, {a[31:12], a[11:6], way});
    chk(ld_done_o == exp_done, "R5", "done at tag write", 64'(ld_done_o), 64'(exp_done));
    if (exp_done) chk(ld_data_o == exp_data, "R5", "data at tag write", ld_data_o, exp_data);
    @(negedge clk_i); #1;
    chk(!busy_o && !tag_we_o && !ld_done_o, "R9", "release",
        {61'd0, busy_o, tag_we_o, ld_done_o}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #5;
    chk(!busy_o && !wb_cyc_o && !wb_stb_o && !ld_done_o && !arr_we_o && !tag_we_o,
        "R1", "in reset", {58'd0, busy_o, wb_cyc_o, wb_stb_o, ld_done_o, arr_we_o, tag_we_o}, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk(!busy_o && !wb_cyc_o && !ld_stall_o && !tag_we_o, "R1", "after reset",
        {60'd0, busy_o, wb_cyc_o, ld_stall_o, tag_we_o}, 0);
    // R11: hit-type load while idle starts nothing
    ld_valid_i = 1'b1; ld_miss_i = 1'b0; ld_addr_i = 32'h0000_4448;
    #1 chk(!ld_stall_o, "R8", "idle stall", 64'(ld_stall_o), 0);
    @(negedge clk_i); ld_valid_i = 1'b0; #1;
    chk(!busy_o && !wb_cyc_o && !ld_done_o, "R11", "no refill",
        {61'd0, busy_o, wb_cyc_o, ld_done_o}, 0);
    for (int i = 0; i < NV; i++) run_vec(VEC[i]);
    // R1: reset in the middle of a refill
    @(negedge clk_i);
    ld_valid_i = 1'b1; ld_miss_i = 1'b1; ld_addr_i = 32'h0000_0A18; ld_way_i = 2'd2;
    @(negedge clk_i); ld_valid_i = 1'b0; ld_miss_i = 1'b0;
    #1 chk(busy_o && wb_stb_o, "R2", "refill started", {62'd0, busy_o, wb_stb_o}, 64'd3);
    rst_ni = 1'b0; #1;
    chk(!busy_o && !wb_cyc_o && !wb_stb_o, "R1", "async reset",
        {61'd0, busy_o, wb_cyc_o, wb_stb_o}, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk(!busy_o && !ld_done_o, "R1", "stays idle", {62'd0, busy_o, ld_done_o}, 0);
    run_vec(VEC[1]);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule